// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block controls a successive-approximation converter from the system clock side. Software programs one 8-bit control/status register. A prescaler turns the system clock into a one-cycle ADC clock enable. Each conversion is a fixed number of those ADC ticks. The sequencer runs a sample phase and then resolves a binary code by trial. It presents each trial code on `dac_o` and reads back a comparator line. The finished code is latched into a result register.

A conversion starts in one of three ways. Software can write the start bit. A rising edge on the trigger line can start one when auto-triggering is on. In free-running mode a new conversion starts as soon as the previous one completes. The first conversion after the block is enabled is longer, because it includes an initialization sequence. Completion sets a flag. The flag drives an interrupt request through two gates: a local interrupt-enable bit and a global enable input. The flag is cleared by an acknowledge pulse or by writing one to it.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, the register reads 8'h00, `irq_o` is 0, `result_o` is 0, and no ADC tick is produced.
- R2: The register read layout is: bit7 enable, bit6 start/busy, bit5 auto-trigger, bit4 done flag, bit3 interrupt enable, bits2..0 prescaler code. A write stores bits 7, 5, 3 and 2..0, and these read back unchanged.
- R3: While the block is enabled, `adc_clk_en_o` is a single-cycle pulse. It repeats every 2 system cycles for codes 0 and 1, and every 2^code cycles for codes 2..7. It stays 0 while the block is disabled.
- R4: A conversion that is not the first after enabling lasts 13 ADC ticks.
- R5: The first conversion after enable is set lasts 25 ADC ticks. This includes a conversion started by the same write that sets enable.
- R6: Bit6 reads 1 from the start of a conversion until it completes. Writing 0 to bit6 starts nothing. A start write whose data has bit7 = 0 starts nothing.
- R7: The code is resolved MSB first. Each trial sets the next bit on `dac_o`, and `cmp_i` = 1 keeps that bit. `result_o` changes only at completion, where it takes the resolved code.
- R8: Completion sets the flag. `irq_o` is 1 exactly when the flag, bit3 and `glob_ie_i` are all 1.
- R9: The flag clears on a write with bit4 = 1 or on an `irq_ack_i` pulse. A write with bit4 = 0 leaves it unchanged. If a completion and a clear fall in the same cycle, the completion wins.
- R10: A write with bit7 = 0 aborts a running conversion on that clock edge. No flag is set and the result is not updated, and the next conversion is a 25-tick one.
- R11: With bit5 = 1 and `free_run_i` = 1, a start write begins a chain of conversions. Each conversion after the first begins at the completion of the previous one, lasts 13 ticks, and bit6 stays 1 throughout.
- R12: With bit5 = 1 and `free_run_i` = 0, a rising edge of `trig_i` starts a conversion, while a held high level does not. A trigger edge or start write that arrives during a conversion is dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| free_run_i | input | 1 | Auto-trigger source: 1 chains conversions, 0 uses `trig_i` |
| trig_i | input | 1 | External trigger line |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above `dac_o` |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| glob_ie_i | input | 1 | Global interrupt enable |
| adc_clk_en_o | output | 1 | ADC clock enable pulse |
| sample_o | output | 1 | Sample phase active |
| dac_o | output | 10 | Trial code for the DAC |
| result_o | output | 10 | Last completed conversion result |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong tick counter or a stale initialization state shows up at the first completion. The busy bit falls after the wrong number of ADC ticks, so the error is visible within one conversion time. A corrupted trial register shows as a wrong `result_o` at that same completion, when the comparator model is driven by a known input level. A flag or abort fault shows as a completion the scoreboard did not expect, or as a missing one, within one conversion length of the stimulus.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  localparam int RES_W    = 10;
  localparam int NORM_CYC = 13;
  localparam int INIT_CYC = 25;
  localparam int PS_W     = 3;

  // software view of the control/status register, MSB first
  typedef struct packed {
    logic            en;
    logic            go;
    logic            ate;
    logic            flag;
    logic            ie;
    logic [PS_W-1:0] ps;
  } ctrl_reg_t;

endpackage

// File: rtl/sar_prescale.sv
module sar_prescale #(
  parameter int PS_W = 3,
  localparam int CNT_W = (1 << PS_W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] code_i,
  output logic            tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;

  // codes 0 and 1 both divide by two, higher codes by 2^code
  always_comb begin
    if (code_i < PS_W'(2)) lim = CNT_W'(1);
    else                   lim = CNT_W'((32'd1 << code_i) - 32'd1);
  end

  // ">=" keeps the divider from overrunning when the code shrinks mid-count
  assign tick_o = en_i && (cnt_q >= lim);

  always_comb begin
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W    = 10,
  parameter int NORM_CYC = 13,
  parameter int INIT_CYC = 25,
  localparam int CYC_W   = $clog2(INIT_CYC),
  localparam int EXTRA   = INIT_CYC - NORM_CYC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             long_i,
  input  logic             chain_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o
);

  logic             busy_q, busy_d;
  logic             long_q, long_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;

  logic [CYC_W-1:0] off, last, rel;
  logic             in_win;
  logic [RES_W-1:0] trial;

  // the long conversion shifts every phase back by the init cycles
  assign off    = long_q ? CYC_W'(EXTRA) : '0;
  assign last   = off + CYC_W'(NORM_CYC - 1);
  assign rel    = cyc_q - off;
  assign in_win = busy_q && (cyc_q > off) && (rel <= CYC_W'(RES_W));

  // one trial bit per resolve cycle, MSB first
  for (genvar i = 0; i < RES_W; i++) begin : g_trial
    assign trial[i] = in_win && (rel == CYC_W'(RES_W - i));
  end

  assign done_o   = busy_q && tick_i && !abort_i && (cyc_q == last);
  assign sample_o = busy_q && (cyc_q <= off);
  assign dac_o    = sar_q | trial;
  assign busy_o   = busy_q;
  assign result_o = res_q;

  always_comb begin
    busy_d = busy_q;
    long_d = long_q;
    cyc_d  = cyc_q;
    sar_d  = sar_q;
    res_d  = res_q;
    if (abort_i) begin
      busy_d = 1'b0;
    end else if (start_i && !busy_q) begin
      busy_d = 1'b1;
      long_d = long_i;
      cyc_d  = '0;
      sar_d  = '0;
    end else if (busy_q && tick_i) begin
      if (done_o) begin
        res_d = sar_q;
        if (chain_i) begin
          long_d = 1'b0;
          cyc_d  = '0;
          sar_d  = '0;
        end else begin
          busy_d = 1'b0;
        end
      end else begin
        cyc_d = cyc_q + 1'b1;
        sar_d = (sar_q & ~trial) | (trial & {RES_W{cmp_i}});
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      long_q <= 1'b0;
      cyc_q  <= '0;
      sar_q  <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      long_q <= long_d;
      cyc_q  <= cyc_d;
      sar_q  <= sar_d;
      res_q  <= res_d;
    end
  end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int RES_W    = sar_conv_pkg::RES_W,
  parameter int NORM_CYC = sar_conv_pkg::NORM_CYC,
  parameter int INIT_CYC = sar_conv_pkg::INIT_CYC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             free_run_i,
  input  logic             trig_i,
  input  logic             cmp_i,
  input  logic             irq_ack_i,
  input  logic             glob_ie_i,
  output logic             adc_clk_en_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);

  ctrl_reg_t       wr;
  ctrl_reg_t       rd;
  logic            en_q, en_d;
  logic            ate_q, ate_d;
  logic            ie_q, ie_d;
  logic            flag_q, flag_d;
  logic [PS_W-1:0] ps_q, ps_d;
  logic            init_q, init_d;
  logic            trig_q;

  logic tick, busy, done;
  logic abort, start_sw, start_hw, start, chain;

  assign wr = ctrl_reg_t'(reg_wdata_i);

  // software controls decoded from the write
  assign abort    = reg_wr_i && !wr.en;
  assign start_sw = reg_wr_i && wr.en && wr.go;
  assign start_hw = en_q && ate_q && !free_run_i && trig_i && !trig_q;
  assign start    = (start_sw || start_hw) && !busy;
  assign chain    = ate_q && free_run_i;

  sar_prescale #(.PS_W(PS_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .code_i (ps_q),
    .tick_o (tick)
  );

  sar_engine #(
    .RES_W    (RES_W),
    .NORM_CYC (NORM_CYC),
    .INIT_CYC (INIT_CYC)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .start_i  (start),
    .abort_i  (abort),
    .long_i   (!init_q),
    .chain_i  (chain),
    .cmp_i    (cmp_i),
    .busy_o   (busy),
    .done_o   (done),
    .sample_o (sample_o),
    .dac_o    (dac_o),
    .result_o (result_o)
  );

  always_comb begin
    en_d  = en_q;
    ate_d = ate_q;
    ie_d  = ie_q;
    ps_d  = ps_q;
    if (reg_wr_i) begin
      en_d  = wr.en;
      ate_d = wr.ate;
      ie_d  = wr.ie;
      ps_d  = wr.ps;
    end
    // completion outranks any clear in the same cycle
    if (done)                                flag_d = 1'b1;
    else if ((reg_wr_i && wr.flag) || irq_ack_i) flag_d = 1'b0;
    else                                     flag_d = flag_q;
    // initialization is owed again after every disable or abort
    if (!en_q || abort) init_d = 1'b0;
    else if (done)      init_d = 1'b1;
    else                init_d = init_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ate_q  <= 1'b0;
      ie_q   <= 1'b0;
      ps_q   <= '0;
      flag_q <= 1'b0;
      init_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ate_q  <= ate_d;
      ie_q   <= ie_d;
      ps_q   <= ps_d;
      flag_q <= flag_d;
      init_q <= init_d;
      trig_q <= trig_i;
    end
  end

  always_comb begin
    rd.en   = en_q;
    rd.go   = busy;
    rd.ate  = ate_q;
    rd.flag = flag_q;
    rd.ie   = ie_q;
    rd.ps   = ps_q;
  end

  assign reg_rdata_o  = rd;
  assign adc_clk_en_o = tick;
  assign irq_o        = flag_q && ie_q && glob_ie_i;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [7:0]       reg_wdata_i,
  input logic [7:0]       reg_rdata_o,
  input logic             irq_ack_i,
  input logic             adc_clk_en_o,
  input logic [RES_W-1:0] result_o
);

  assert_busy_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] |-> reg_rdata_o[7]);

  assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_en_o |=> !adc_clk_en_o);

  assert_tick_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_en_o |-> reg_rdata_o[7]);

  assert_flag_from_conv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[4]) |-> $past(reg_rdata_o[6]));

  assert_result_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> reg_rdata_o[4]);

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !reg_rdata_o[6]) |=> !reg_rdata_o[4]);

  assert_idle_no_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_wdata_i[6] && !reg_rdata_o[6] && !reg_rdata_o[5]) |=> !reg_rdata_o[6]);

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_ack_i    (irq_ack_i),
  .adc_clk_en_o (adc_clk_en_o),
  .result_o     (result_o)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       free_run = 1'b0;
  logic       trig = 1'b0;
  logic       cmp;
  logic       ack = 1'b0;
  logic       gie = 1'b1;
  logic       tick, sample, irq;
  logic [9:0] dac, result;
  logic [9:0] vin = 10'd0;

  int n_chk = 0;
  int n_bad = 0;
  logic [9:0] q_res[$];
  int         q_len[$];
  int         tick_cnt = 0;
  logic       flag_prev = 1'b0;

  always #10 clk = ~clk;

  // comparator model: input at or above the trial code
  assign cmp = (vin >= dac);

  sar_conv_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .free_run_i(free_run), .trig_i(trig), .cmp_i(cmp),
    .irq_ack_i(ack), .glob_ie_i(gie), .adc_clk_en_o(tick), .sample_o(sample),
    .dac_o(dac), .result_o(result), .irq_o(irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: counts ADC ticks of the running conversion, pops on each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdata[4] && !flag_prev) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R10/R12 unexpected completion", 1, 0);
        end else begin
          automatic logic [9:0] er = q_res.pop_front();
          automatic int el = q_len.pop_front();
          check(result == er, "R7 result", result, er);
          check(tick_cnt == el, (el == 25) ? "R5 length" : "R4 length", tick_cnt, el);
        end
        tick_cnt = 0;
      end
      if (!rdata[6]) tick_cnt = 0;
      if (rdata[6] && tick) tick_cnt++;
      flag_prev = rdata[4];
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    wdata  = d;
    @(negedge clk);
    reg_wr = 1'b0;
    wdata  = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (rdata[6] && n < 5000) begin @(negedge clk); n++; end
    check(n < 5000, "R6 busy timeout", n, 0);
  endtask

  task automatic wait_flag();
    int n = 0;
    while (!rdata[4] && n < 5000) begin @(negedge clk); n++; end
    check(n < 5000, "R8 flag timeout", n, 0);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check(rdata[4] == 1'b0, "R9 ack clear", rdata[4], 0);
  endtask

  task automatic conv(input logic [7:0] cfg, input logic [9:0] v, input int len);
    vin = v;
    q_res.push_back(v);
    q_len.push_back(len);
    wr(cfg | 8'h40);
    wait_idle();
    pulse_ack();
  endtask

  task automatic measure_div(input logic [2:0] code, input int exp);
    int n = 0;
    int g = 0;
    wr(8'h80 | {5'd0, code});
    while (!tick && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    g = 1;
    while (!tick && g < 500) begin @(negedge clk); g++; end
    check(g == exp, "R3 divide", g, exp);
  endtask

  initial begin
    #3ms;
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] cfg;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check(rdata == 8'h00, "R1 rdata", rdata, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(result == 10'd0, "R1 result", result, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (tick) seen++; end
      check(seen == 0, "R3 no tick when disabled", seen, 0);
    end

    // R2 readback of stored fields (start bit clear, flag clear)
    wr(8'hAD);
    check(rdata == 8'hAD, "R2 readback", rdata, 8'hAD);
    wr(8'h00);

    // R5 enable and start in one write; R6 busy readback
    cfg = 8'h88;
    vin = 10'd600;
    q_res.push_back(10'd600);
    q_len.push_back(25);
    wr(cfg | 8'h40);
    idle(3);
    check(rdata[6] == 1'b1, "R6 busy during conversion", rdata[6], 1);
    wait_idle();

    // R8 interrupt gating
    check(irq == 1'b1, "R8 irq asserted", irq, 1);
    gie = 1'b0;
    #1 check(irq == 1'b0, "R8 global gate", irq, 0);
    gie = 1'b1;
    wr(cfg & 8'hF7);
    check(irq == 1'b0, "R8 local gate", irq, 0);
    // R9 write 0 keeps, write 1 clears
    wr(cfg);
    check(rdata[4] == 1'b1, "R9 write zero keeps flag", rdata[4], 1);
    wr(cfg | 8'h10);
    check(rdata[4] == 1'b0, "R9 write one clears flag", rdata[4], 0);

    // R4 and R7 normal conversions across codes
    conv(cfg, 10'd0, 13);
    conv(cfg, 10'd1023, 13);
    conv(cfg, 10'd341, 13);

    // R6 writing 0 to start has no effect
    wr(cfg);
    idle(5);
    check(rdata[6] == 1'b0, "R6 zero start write", rdata[6], 0);
    // R6 start with enable clear is ignored
    wr(8'h40);
    idle(5);
    check(rdata[6] == 1'b0, "R6 start while disabled", rdata[6], 0);

    // R10 abort mid conversion
    vin = 10'd900;
    wr(cfg | 8'h40);
    idle(10);
    wr(8'h00);
    check(rdata[6] == 1'b0, "R10 abort busy", rdata[6], 0);
    idle(80);
    check(rdata[4] == 1'b0, "R10 no flag after abort", rdata[4], 0);
    check(result == 10'd341, "R10 result kept", result, 341);
    wr(cfg);
    conv(cfg, 10'd512, 25);

    // R12 start during busy is dropped
    vin = 10'd200;
    q_res.push_back(10'd200);
    q_len.push_back(13);
    wr(cfg | 8'h40);
    idle(6);
    wr(cfg | 8'h40);
    wait_idle();
    pulse_ack();
    idle(40);
    check(q_res.size() == 0, "R12 busy start dropped", q_res.size(), 0);

    // R3 divide ratios, then a conversion on a slower tick
    measure_div(3'd0, 2);
    measure_div(3'd1, 2);
    measure_div(3'd3, 8);
    measure_div(3'd7, 128);
    conv(8'h8B, 10'd77, 13);

    // R11 free-running chain
    free_run = 1'b1;
    cfg = 8'hA8;
    vin = 10'd777;
    for (int k = 0; k < 3; k++) begin
      q_res.push_back(10'd777);
      q_len.push_back(13);
    end
    wr(cfg | 8'h40);
    for (int k = 0; k < 3; k++) begin
      wait_flag();
      check(rdata[6] == 1'b1, "R11 busy across chain", rdata[6], 1);
      pulse_ack();
    end
    wr(8'h00);
    check(q_res.size() == 0, "R11 chain count", q_res.size(), 0);
    free_run = 1'b0;

    // R12 trigger edge; first after enable is long
    wr(cfg);
    vin = 10'd55;
    q_res.push_back(10'd55);
    q_len.push_back(25);
    @(negedge clk) trig = 1'b1;
    idle(2);
    wait_idle();
    pulse_ack();
    idle(60);
    check(rdata[6] == 1'b0, "R12 level does not retrigger", rdata[6], 0);
    @(negedge clk) trig = 1'b0;
    vin = 10'd900;
    q_res.push_back(10'd900);
    q_len.push_back(13);
    @(negedge clk) trig = 1'b1;
    idle(8);
    trig = 1'b0;
    idle(2);
    trig = 1'b1;
    idle(2);
    wait_idle();
    pulse_ack();
    idle(60);
    check(q_res.size() == 0, "R12 busy trigger dropped", q_res.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule